// File: doc/BRIEF.md
# Keyed Register Lock and Checksum

This block holds a small bank of configuration and calibration registers that two masters can write: the internal calculation engine and the host serial interface. Each master has its own write port with address, data and write enable. Each master also has its own lock, and a separate 5-bit key field controls each lock. Writing 0x16 into a key field arms that master's lock. Writing 0x09 releases it. Any other key value leaves the lock as it was. Three parameter masks give each register its attributes: whether the engine's lock can block it, whether the host's lock can block it, and whether it counts toward the checksum.

A low-rate cycle strobe starts a background pass. The pass adds up the flagged registers, one register per clock, modulo 2^24. When the pass finishes, the sum goes into a readable result register, which is also driven on a dedicated output. A control bit turns the automatic checksum off. While the checksum is off, the last result is kept.

Top module: `wrprot_top`

## Requirements
- R1: With default parameters, addresses 0..7 select the bank registers, 8 the lock register, 9 the control register and 10 the checksum result. A write that is not blocked lands on the clock edge and reads back at once through the combinational read port. Unmapped addresses read zero.
- R2: A write to the lock register carries the engine key in data bits [4:0]. Key 0x16 locks the engine port and key 0x09 unlocks it. The engine lock state reads back at lock register bit 0.
- R3: The host key sits in lock register write bits [12:8] and uses the same two key values. The host lock state reads back at lock register bit 8.
- R4: While a port is locked, its writes to registers whose mask marks them lockable by that port are ignored. Its writes to other registers still land. The other port is unaffected.
- R5: Key values other than 0x16 and 0x09 leave the lock state unchanged. Either port can write the lock register at any time, whatever the lock state.
- R6: When both ports write the same register in one cycle, the host data is stored, unless the host write is blocked, in which case the engine write applies. The same rule applies to the lock and control registers.
- R7: The checksum is the sum, modulo 2^24, of the registers flagged in the checksum mask (default: registers 1..6). A strobe starts a pass when none is running. The result register and `csum_o` change exactly N_REGS clock edges after the strobe edge, and not earlier.
- R8: When control bit 0 is 1, strobes are ignored, a pass already running is abandoned, and the result register keeps its value.
- R9: After reset, all bank registers, both locks, the control bit and the result are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | 4 | Engine write address |
| eng_wdata | input | 24 | Engine write data |
| host_we | input | 1 | Host write enable |
| host_addr | input | 4 | Host write address |
| host_wdata | input | 24 | Host write data |
| lowrate_stb | input | 1 | Low-rate cycle strobe, starts a checksum pass |
| rd_addr | input | 4 | Read address |
| rd_data | output | 24 | Read data for rd_addr |
| csum_o | output | 24 | Current checksum result |

## Verification
On every cycle, the assertions check the following:
- A locked port never changes a register that its lock protects.
- A key other than 0x16 or 0x09 leaves the engine lock unchanged.
- An unblocked host write wins a same-cycle collision.
- The result register moves only at the end of a pass that is enabled.
- The result register is frozen while the checksum is disabled.

Some behaviour can only be shown by the bench's scenarios: the exact value of the sum, including wrap-around past 24 bits; the N_REGS-cycle latency from strobe to result; abandoning a pass midway; and the engine taking over a collision when the host write is blocked.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;
    localparam logic [4:0] KEY_LOCK   = 5'h16;
    localparam logic [4:0] KEY_UNLOCK = 5'h09;

    typedef enum logic [0:0] {
        CS_IDLE = 1'b0,
        CS_RUN  = 1'b1
    } cs_state_e;
endpackage

// File: rtl/wrprot_lock.sv
module wrprot_lock
    import wrprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [4:0] key_eng,
    input  logic [4:0] key_host,
    output logic       eng_locked,
    output logic       host_locked
);
    typedef struct packed {
        logic eng;
        logic host;
    } lock_s;

    lock_s lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (wr_en) begin
            if (key_eng == KEY_LOCK)          lk_d.eng = 1'b1;
            else if (key_eng == KEY_UNLOCK)   lk_d.eng = 1'b0;
            if (key_host == KEY_LOCK)         lk_d.host = 1'b1;
            else if (key_host == KEY_UNLOCK)  lk_d.host = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '0;
        else        lk_q <= lk_d;
    end

    assign eng_locked  = lk_q.eng;
    assign host_locked = lk_q.host;
endmodule

// File: rtl/wrprot_csum.sv
module wrprot_csum
    import wrprot_pkg::*;
#(
    parameter int                N_REGS    = 8,
    parameter int                DATA_W    = 24,
    parameter logic [N_REGS-1:0] CSUM_MASK = '1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic                           start,
    input  logic [N_REGS-1:0][DATA_W-1:0]  regs,
    output logic [DATA_W-1:0]              result,
    output logic                           busy
);
    localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REGS - 1);

    typedef struct packed {
        cs_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] res;
    } cs_s;

    cs_s cs_d, cs_q;
    logic [DATA_W-1:0] term;

    always_comb begin
        term = CSUM_MASK[cs_q.idx] ? regs[cs_q.idx] : '0;
        cs_d = cs_q;
        if (!enable) begin
            cs_d.st = CS_IDLE;
        end else begin
            case (cs_q.st)
                CS_IDLE: begin
                    if (start) begin
                        cs_d.st  = CS_RUN;
                        cs_d.idx = '0;
                        cs_d.acc = '0;
                    end
                end
                CS_RUN: begin
                    cs_d.acc = cs_q.acc + term;
                    if (cs_q.idx == LAST_IDX) begin
                        cs_d.res = cs_q.acc + term;
                        cs_d.st  = CS_IDLE;
                    end else begin
                        cs_d.idx = cs_q.idx + 1'b1;
                    end
                end
                default: cs_d.st = CS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '{st: CS_IDLE, idx: '0, acc: '0, res: '0};
        else        cs_q <= cs_d;
    end

    assign result = cs_q.res;
    assign busy   = (cs_q.st == CS_RUN);
endmodule

// File: rtl/wrprot_top.sv
module wrprot_top #(
    parameter int                N_REGS         = 8,
    parameter int                DATA_W         = 24,
    parameter logic [N_REGS-1:0] ENG_LOCK_MASK  = 8'h0F,
    parameter logic [N_REGS-1:0] HOST_LOCK_MASK = 8'h3C,
    parameter logic [N_REGS-1:0] CSUM_MASK      = 8'h7E,
    localparam int               ADDR_W         = $clog2(N_REGS + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_we,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              lowrate_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] csum_o
);
    localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(N_REGS);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_REGS + 1);
    localparam logic [ADDR_W-1:0] CSUM_ADDR = ADDR_W'(N_REGS + 2);
    localparam logic [ADDR_W-1:0] BANK_END  = ADDR_W'(N_REGS);

    typedef struct packed {
        logic [N_REGS-1:0][DATA_W-1:0] regs;
        logic                          csum_off;
    } top_s;

    top_s st_d, st_q;

    logic eng_locked, host_locked;
    logic csum_busy;
    logic [DATA_W-1:0] csum_q;
    logic [N_REGS-1:0][DATA_W-1:0] bank_q;
    logic csum_off;

    logic [IDX_W-1:0] eng_idx, host_idx, rd_idx;
    logic eng_ok, host_ok;
    logic eng_lock_wr, host_lock_wr, eng_ctrl_wr, host_ctrl_wr;
    logic [4:0] key_eng, key_host;

    assign eng_idx  = eng_addr[IDX_W-1:0];
    assign host_idx = host_addr[IDX_W-1:0];
    assign rd_idx   = rd_addr[IDX_W-1:0];

    assign eng_ok  = eng_we  && (eng_addr  < BANK_END) &&
                     !(eng_locked  && ENG_LOCK_MASK[eng_idx]);
    assign host_ok = host_we && (host_addr < BANK_END) &&
                     !(host_locked && HOST_LOCK_MASK[host_idx]);

    assign eng_lock_wr  = eng_we  && (eng_addr  == LOCK_ADDR);
    assign host_lock_wr = host_we && (host_addr == LOCK_ADDR);
    assign eng_ctrl_wr  = eng_we  && (eng_addr  == CTRL_ADDR);
    assign host_ctrl_wr = host_we && (host_addr == CTRL_ADDR);

    assign key_eng  = host_lock_wr ? host_wdata[4:0]  : eng_wdata[4:0];
    assign key_host = host_lock_wr ? host_wdata[12:8] : eng_wdata[12:8];

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_REGS; i++) begin
            if (host_ok && host_idx == IDX_W'(i))
                st_d.regs[i] = host_wdata;
            else if (eng_ok && eng_idx == IDX_W'(i))
                st_d.regs[i] = eng_wdata;
        end
        if (host_ctrl_wr)     st_d.csum_off = host_wdata[0];
        else if (eng_ctrl_wr) st_d.csum_off = eng_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank_q   = st_q.regs;
    assign csum_off = st_q.csum_off;

    wrprot_lock u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (eng_lock_wr || host_lock_wr),
        .key_eng     (key_eng),
        .key_host    (key_host),
        .eng_locked  (eng_locked),
        .host_locked (host_locked)
    );

    wrprot_csum #(
        .N_REGS    (N_REGS),
        .DATA_W    (DATA_W),
        .CSUM_MASK (CSUM_MASK)
    ) u_csum (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (!st_q.csum_off),
        .start  (lowrate_stb),
        .regs   (st_q.regs),
        .result (csum_q),
        .busy   (csum_busy)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr < BANK_END) begin
            rd_data = st_q.regs[rd_idx];
        end else if (rd_addr == LOCK_ADDR) begin
            rd_data[0] = eng_locked;
            rd_data[8] = host_locked;
        end else if (rd_addr == CTRL_ADDR) begin
            rd_data[0] = st_q.csum_off;
        end else if (rd_addr == CSUM_ADDR) begin
            rd_data = csum_q;
        end
    end

    assign csum_o = csum_q;
endmodule

// File: rtl/wrprot_chk.sv
module wrprot_chk
    import wrprot_pkg::*;
#(
    parameter int                N_REGS         = 8,
    parameter int                DATA_W         = 24,
    parameter logic [N_REGS-1:0] ENG_LOCK_MASK  = 8'h0F,
    parameter logic [N_REGS-1:0] HOST_LOCK_MASK = 8'h3C,
    parameter int                ADDR_W         = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          eng_we,
    input logic [ADDR_W-1:0]             eng_addr,
    input logic [DATA_W-1:0]             eng_wdata,
    input logic                          host_we,
    input logic [ADDR_W-1:0]             host_addr,
    input logic [DATA_W-1:0]             host_wdata,
    input logic                          eng_locked,
    input logic                          host_locked,
    input logic [N_REGS-1:0][DATA_W-1:0] bank_q,
    input logic [DATA_W-1:0]             csum_q,
    input logic                          csum_busy,
    input logic                          csum_off
);
    localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(N_REGS);
    localparam logic [ADDR_W-1:0] BANK_END  = ADDR_W'(N_REGS);

    logic [IDX_W-1:0] eidx, hidx;
    assign eidx = eng_addr[IDX_W-1:0];
    assign hidx = host_addr[IDX_W-1:0];

    assert_eng_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && eng_locked && eng_addr < BANK_END && ENG_LOCK_MASK[eidx] &&
         !(host_we && host_addr == eng_addr))
        |=> bank_q[$past(eidx)] == $past(bank_q[eidx]));

    assert_host_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_locked && host_addr < BANK_END && HOST_LOCK_MASK[hidx] &&
         !(eng_we && eng_addr == host_addr))
        |=> bank_q[$past(hidx)] == $past(bank_q[hidx]));

    assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && eng_addr == LOCK_ADDR && !(host_we && host_addr == LOCK_ADDR) &&
         eng_wdata[4:0] != KEY_LOCK && eng_wdata[4:0] != KEY_UNLOCK)
        |=> $stable(eng_locked));

    assert_host_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && eng_we && host_addr == eng_addr && host_addr < BANK_END &&
         !(host_locked && HOST_LOCK_MASK[hidx]))
        |=> bank_q[$past(hidx)] == $past(host_wdata));

    assert_csum_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csum_q) |-> ($past(csum_busy) && !$past(csum_off)));

    assert_csum_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        csum_off |=> $stable(csum_q));
endmodule

bind wrprot_top wrprot_chk #(
    .N_REGS         (N_REGS),
    .DATA_W         (DATA_W),
    .ENG_LOCK_MASK  (ENG_LOCK_MASK),
    .HOST_LOCK_MASK (HOST_LOCK_MASK),
    .ADDR_W         (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_we      (eng_we),
    .eng_addr    (eng_addr),
    .eng_wdata   (eng_wdata),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .eng_locked  (eng_locked),
    .host_locked (host_locked),
    .bank_q      (bank_q),
    .csum_q      (csum_q),
    .csum_busy   (csum_busy),
    .csum_off    (csum_off)
);

// File: tb/tb_wrprot_top.sv
module tb_wrprot_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eng_we = 1'b0, host_we = 1'b0, lowrate_stb = 1'b0;
    logic [3:0]  eng_addr = '0, host_addr = '0, rd_addr = '0;
    logic [23:0] eng_wdata = '0, host_wdata = '0;
    logic [23:0] rd_data, csum_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    wrprot_top dut (
        .clk(clk), .rst_n(rst_n),
        .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .lowrate_stb(lowrate_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .csum_o(csum_o)
    );

    // {host_sel, wr_addr, wr_data, chk_addr, expected}
    localparam int NV = 13;
    localparam logic [56:0] VEC [NV] = '{
        {1'b0, 4'd0, 24'h111111, 4'd0, 24'h111111},
        {1'b1, 4'd4, 24'h444444, 4'd4, 24'h444444},
        {1'b0, 4'd8, 24'h000016, 4'd8, 24'h000001},
        {1'b0, 4'd1, 24'hAAAAAA, 4'd1, 24'h000000},
        {1'b0, 4'd5, 24'h555555, 4'd5, 24'h555555},
        {1'b1, 4'd1, 24'h0A0A0A, 4'd1, 24'h0A0A0A},
        {1'b0, 4'd8, 24'h000005, 4'd8, 24'h000001},
        {1'b1, 4'd8, 24'h001600, 4'd8, 24'h000101},
        {1'b1, 4'd3, 24'h333333, 4'd3, 24'h000000},
        {1'b1, 4'd7, 24'h777777, 4'd7, 24'h777777},
        {1'b0, 4'd3, 24'h123456, 4'd3, 24'h000000},
        {1'b1, 4'd8, 24'h000909, 4'd8, 24'h000000},
        {1'b0, 4'd3, 24'h030303, 4'd3, 24'h030303}
    };
    localparam string TAGS [NV] = '{
        "R1", "R1", "R2", "R4", "R4", "R4", "R5",
        "R3", "R4", "R4", "R4", "R5", "R2"
    };

    task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %06h expected %06h", tag, act, exp);
        end
    endtask

    task automatic check_rd(input logic [3:0] a, input logic [23:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(rd_data, exp, tag);
    endtask

    task automatic wr(input bit host, input logic [3:0] a, input logic [23:0] d);
        @(negedge clk);
        if (host) begin host_we = 1'b1; host_addr = a; host_wdata = d; end
        else      begin eng_we  = 1'b1; eng_addr  = a; eng_wdata  = d; end
        @(negedge clk);
        host_we = 1'b0;
        eng_we  = 1'b0;
    endtask

    task automatic wr_both(input logic [3:0] a, input logic [23:0] de, input logic [23:0] dh);
        @(negedge clk);
        eng_we = 1'b1;  eng_addr = a;  eng_wdata = de;
        host_we = 1'b1; host_addr = a; host_wdata = dh;
        @(negedge clk);
        host_we = 1'b0;
        eng_we  = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        lowrate_stb = 1'b1;
        @(negedge clk);
        lowrate_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check_rd(4'd0, 24'h0, "R9");
        check_rd(4'd8, 24'h0, "R9");
        check_rd(4'd9, 24'h0, "R9");
        check_rd(4'd10, 24'h0, "R9");
        check(csum_o, 24'h0, "R9");
        check_rd(4'd15, 24'h0, "R1");

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][56], VEC[i][55:52], VEC[i][51:28]);
            check_rd(VEC[i][27:24], VEC[i][23:0], TAGS[i]);
        end

        // R7: sum of r1,r3,r4,r5 = A6A6A6, appears after 8 edges exactly
        strobe();
        repeat (7) @(negedge clk);
        check_rd(4'd10, 24'h0, "R7");
        @(negedge clk);
        check_rd(4'd10, 24'hA6A6A6, "R7");
        check(csum_o, 24'hA6A6A6, "R7");

        // R7: wrap past 24 bits, r0 and r7 not flagged
        wr(1'b1, 4'd6, 24'hFFFFFF);
        strobe();
        repeat (9) @(negedge clk);
        check_rd(4'd10, 24'hA6A6A5, "R7");

        // R8: disabled, strobe ignored
        wr(1'b1, 4'd9, 24'h000001);
        check_rd(4'd9, 24'h000001, "R8");
        wr(1'b0, 4'd2, 24'h000001);
        strobe();
        repeat (12) @(negedge clk);
        check_rd(4'd10, 24'hA6A6A5, "R8");

        // R8: pass abandoned midway
        wr(1'b0, 4'd9, 24'h000000);
        strobe();
        repeat (2) @(negedge clk);
        wr(1'b0, 4'd9, 24'h000001);
        repeat (12) @(negedge clk);
        check(csum_o, 24'hA6A6A5, "R8");

        // R7: re-enabled pass picks up r2
        wr(1'b0, 4'd9, 24'h000000);
        strobe();
        repeat (9) @(negedge clk);
        check(csum_o, 24'hA6A6A6, "R7");

        // R6: collision, host wins
        wr_both(4'd7, 24'h0E0E0E, 24'h0F0F0F);
        check_rd(4'd7, 24'h0F0F0F, "R6");
        // R6: collision with blocked host, engine applies
        wr(1'b1, 4'd8, 24'h001600);
        wr_both(4'd4, 24'h0E0E0E, 24'h0F0F0F);
        check_rd(4'd4, 24'h0E0E0E, "R6");
        // R6: collision on lock register, host data used
        wr_both(4'd8, 24'h000016, 24'h000909);
        check_rd(4'd8, 24'h000000, "R6");

        finish_run();
    end
endmodule